// File: doc/BRIEF.md
# Status Register and Write-Protect Guard

This block keeps the eight-bit status word of a serial nonvolatile memory and rules on every write the command controller wants to start. It holds three retained configuration bits (a status-lock bit and a two-bit protect-range field), a write-enable latch, and a write-in-progress indication. The retained bits are modelled as ordinary registers. The command controller sends it one-cycle strobes: latch set, latch clear, status write with a data byte, and write finished. It also sends its own busy level for memory writes, the current target address, the active-low protect pin and a brown-out event. In return the block gives the status byte and two permit flags.

A status write goes through a two-state machine. In `ST_IDLE` a status write request is accepted when the permit is high: the transition *accept* captures the new bits and moves to `ST_SR_BUSY`. In `ST_SR_BUSY` the old retained bits stay visible and the byte reports a write in progress. The transition *commit*, on write finished, copies the captured bits and returns to `ST_IDLE`. The transition *abort*, on brown-out, returns to `ST_IDLE` and drops the captured bits. The protect pin level is sampled only in the accept cycle, so changing it during the write has no effect on the result.

Top module: `sreg_guard`

## Requirements
- R1: The status byte is {lock, 0, 0, 0, range[1], range[0], latch, busy}: bit 7 is the lock bit, bits 3:2 are the range field, bit 1 is the write-enable latch and bit 0 is the busy flag. Bits 6:4 always read 0. After reset the byte reads 8'h00.
- R2: A committed status write copies data bits 7, 3 and 2 into the lock bit and the range field. The other data bits have no effect on the status byte.
- R3: The range field selects which addresses refuse memory writes. 00 protects none. 01 protects addresses whose two top bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address.
- R4: While the lock bit is 1 and `wp_n` is low, `sr_wr_ok` is 0 and a status write request leaves the retained bits unchanged. With `wp_n` high, only the latch and the busy flag gate status writes.
- R5: `wel_set` sets the latch only when the busy flag is 0. `wel_clr`, `wr_done`, `brownout` and reset clear it. A clear wins over a set in the same cycle.
- R6: While the latch is 0, `mem_wr_ok` and `sr_wr_ok` are both 0.
- R7: From the cycle after acceptance until the `wr_done` edge, the busy flag reads 1 and the retained bits keep their old values. The new values appear in the cycle after `wr_done`, and the latch is cleared at the same time.
- R8: While the busy flag is 1 (`wip_in` high or a status write pending), both permits are 0.
- R9: `brownout` during a pending status write discards it, keeps the old retained bits and clears the latch. This also holds when `wr_done` arrives in the same cycle.
- R10: The `wp_n` level is sampled in the cycle a status write is accepted. Changing `wp_n` afterwards does not change the committed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; loads the delivered default |
| brownout | input | 1 | Low-voltage event: clears the latch and aborts a pending status write |
| wel_set | input | 1 | Strobe: set write-enable latch |
| wel_clr | input | 1 | Strobe: clear write-enable latch |
| sr_wr_req | input | 1 | Strobe: status write request carrying `sr_wr_data` |
| sr_wr_data | input | 8 | Data byte of a status write |
| wr_done | input | 1 | Strobe: internal write (memory or status) finished |
| wip_in | input | 1 | Controller busy with a memory write |
| wp_n | input | 1 | Protect pin, active low |
| mem_addr | input | ADDR_W | Target address of a memory write |
| status | output | 8 | Status byte |
| mem_wr_ok | output | 1 | Memory write to `mem_addr` is permitted |
| sr_wr_ok | output | 1 | Status write is permitted |

## Verification
Two pairs of events can land in the same cycle. Brown-out can coincide with write-finished while a status write is pending, and latch set can coincide with latch clear. Both are driven directly: brown-out must win, so the old retained bits stay and the latch ends at 0, and clear must beat set. The random phase then overlaps all strobes freely against a bench model whose priorities are written from the requirements. The model also covers the case where the protect pin moves between acceptance and commit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_SR_BUSY = 1'b1
    } sreg_state_e;

    // retained configuration bits
    typedef struct packed {
        logic       lock;
        logic [1:0] range;
    } sreg_nv_t;

    localparam int STAT_W    = 8;
    localparam int LOCK_POS  = 7;
    localparam int RNG_HI    = 3;
    localparam int RNG_LO    = 2;

endpackage

// File: rtl/sreg_range_decode.sv
module sreg_range_decode #(
    parameter int ADDR_W = 14
) (
    input  logic [1:0]        range,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    generate
        if (ADDR_W < 2) begin : g_tiny
            // too narrow for quarter split: any nonzero range protects all
            always_comb hit = |range;
        end else begin : g_norm
            always_comb begin
                unique case (range)
                    2'b00: hit = 1'b0;
                    2'b01: hit = &addr[TOP -: 2];   // top quarter
                    2'b10: hit = addr[TOP];         // top half
                    default: hit = 1'b1;            // whole array
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/sreg_wel.sv
module sreg_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic brownout,
    input  logic wr_done,
    input  logic clr,
    input  logic set,
    input  logic busy,
    output logic wel
);
    logic kill;
    assign kill = brownout | wr_done | clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (kill)
            wel <= 1'b0;
        else if (set && !busy)
            wel <= 1'b1;
    end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brownout,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              wr_done,
    input  logic              wip_in,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        status,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    sreg_state_e state_q, state_d;
    sreg_nv_t    nv_q, nv_d, pend_q, pend_d;
    logic        wel;
    logic        busy;
    logic        hw_lock;
    logic        prot_hit;

    sreg_range_decode #(.ADDR_W(ADDR_W)) u_range (
        .range (nv_q.range),
        .addr  (mem_addr),
        .hit   (prot_hit)
    );

    sreg_wel u_wel (
        .clk      (clk),
        .rst_n    (rst_n),
        .brownout (brownout),
        .wr_done  (wr_done),
        .clr      (wel_clr),
        .set      (wel_set),
        .busy     (busy),
        .wel      (wel)
    );

    // state and retained bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nv_q    <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            nv_q    <= nv_d;
            pend_q  <= pend_d;
        end
    end

    // transitions: accept, commit, abort
    always_comb begin
        state_d = state_q;
        nv_d    = nv_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!brownout && sr_wr_req && sr_wr_ok) begin
                    state_d = ST_SR_BUSY;
                    pend_d  = {sr_wr_data[LOCK_POS], sr_wr_data[RNG_HI:RNG_LO]};
                end
            end
            ST_SR_BUSY: begin
                if (brownout) begin
                    state_d = ST_IDLE;
                end else if (wr_done) begin
                    state_d = ST_IDLE;
                    nv_d    = pend_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = wip_in | (state_q == ST_SR_BUSY);
        hw_lock   = nv_q.lock & ~wp_n;
        sr_wr_ok  = wel & ~busy & ~hw_lock;
        mem_wr_ok = wel & ~busy & ~prot_hit;
        status    = {nv_q.lock, 3'b000, nv_q.range, wel, busy};
    end

endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       brownout,
    input logic       sr_wr_req,
    input logic       wr_done,
    input logic       wp_n,
    input logic [7:0] status,
    input logic       mem_wr_ok,
    input logic       sr_wr_ok
);
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);

    p_full_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b11) |-> !mem_wr_ok);

    p_hw_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !wp_n && sr_wr_req && !status[0])
        |=> $stable({status[7], status[3:2]}));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !status[1]);

    p_no_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1] |-> (!mem_wr_ok && !sr_wr_ok));

    p_hold_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !wr_done) |=> $stable({status[7], status[3:2]}));

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (!mem_wr_ok && !sr_wr_ok));

    p_brownout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brownout |=> (!status[1] && $stable({status[7], status[3:2]})));
endmodule

bind sreg_guard sreg_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .brownout  (brownout),
    .sr_wr_req (sr_wr_req),
    .wr_done   (wr_done),
    .wp_n      (wp_n),
    .status    (status),
    .mem_wr_ok (mem_wr_ok),
    .sr_wr_ok  (sr_wr_ok)
);

// File: tb/sreg_guard_test.sv
`timescale 1ns/1ps
module sreg_guard_test;
    localparam int AW = 14;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n, brownout, wel_set, wel_clr, sr_wr_req, wr_done, wip_in, wp_n;
    logic [7:0]    sr_wr_data;
    logic [AW-1:0] mem_addr;
    logic [7:0]    status;
    logic          mem_wr_ok, sr_wr_ok;

    sreg_guard #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .brownout(brownout), .wel_set(wel_set),
        .wel_clr(wel_clr), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
        .wr_done(wr_done), .wip_in(wip_in), .wp_n(wp_n), .mem_addr(mem_addr),
        .status(status), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    bit       m_lock, m_wel, m_busy;
    bit [1:0] m_rng;
    bit [2:0] m_pend;

    function automatic bit prot_f(bit [1:0] r, logic [AW-1:0] a);
        case (r)
            2'b00:   return 1'b0;
            2'b01:   return a[AW-1] & a[AW-2];
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit busy_f();
        return wip_in | m_busy;
    endfunction

    function automatic bit sr_ok_f();
        return m_wel & !busy_f() & !(m_lock & !wp_n);
    endfunction

    function automatic bit mem_ok_f();
        return m_wel & !busy_f() & !prot_f(m_rng, mem_addr);
    endfunction

    function automatic logic [7:0] stat_f();
        return {m_lock, 3'b000, m_rng, m_wel, busy_f()};
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit b = busy_f();
        bit ok = sr_ok_f();
        bit nwel;
        if (brownout || wr_done || wel_clr) nwel = 1'b0;
        else if (wel_set && !b)             nwel = 1'b1;
        else                                nwel = m_wel;
        if (brownout) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            if (wr_done) begin
                {m_lock, m_rng} = m_pend;
                m_busy = 1'b0;
            end
        end else if (sr_wr_req && ok) begin
            m_busy = 1'b1;
            m_pend = {sr_wr_data[7], sr_wr_data[3:2]};
        end
        m_wel = nwel;
    endtask

    task automatic step(string tag, bit bo, bit ws, bit wc, bit sr, logic [7:0] d,
                        bit wd, bit wi, bit wpn, logic [AW-1:0] a);
        @(negedge clk);
        brownout = bo; wel_set = ws; wel_clr = wc; sr_wr_req = sr; sr_wr_data = d;
        wr_done = wd; wip_in = wi; wp_n = wpn; mem_addr = a;
        #1;
        check8(tag, status, stat_f());
        check8(tag, {6'b0, mem_wr_ok, sr_wr_ok}, {6'b0, mem_ok_f(), sr_ok_f()});
        @(posedge clk);
        model_edge();
    endtask

    task automatic nop(string tag, bit wpn);
        step(tag, 0, 0, 0, 0, 8'h00, 0, 0, wpn, '0);
    endtask

    task automatic peek(string tag, logic [7:0] exp);
        @(negedge clk);
        #1;
        check8(tag, status, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; brownout = 0; wel_set = 0; wel_clr = 0; sr_wr_req = 0;
        sr_wr_data = 0; wr_done = 0; wip_in = 0; wp_n = 1; mem_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        peek("R1 reset value", 8'h00);
        nop("R1", 1);

        step("R6 status write without latch", 0, 0, 0, 1, 8'hFF, 0, 0, 1, '0);
        peek("R6 refused", 8'h00);

        step("R5 set latch", 0, 1, 0, 0, 8'h00, 0, 0, 1, '0);
        peek("R5 latch set", 8'h02);
        step("R2 accept FF", 0, 0, 0, 1, 8'hFF, 0, 0, 1, '0);
        peek("R7 old bits while busy", 8'h03);
        for (int i = 0; i < 3; i++) nop("R7 pending", 1);
        step("R2 commit", 0, 0, 0, 0, 8'h00, 1, 0, 1, '0);
        peek("R2 only lock and range written", 8'h8C);

        step("R5 set latch", 0, 1, 0, 0, 8'h00, 0, 0, 1, '0);
        step("R3 full range", 0, 0, 0, 0, 8'h00, 0, 0, 1, 14'h0000);
        step("R4 locked status write", 0, 0, 0, 1, 8'h00, 0, 0, 0, '0);
        peek("R4 refused under hw lock", 8'h8E);

        step("R10 accept with pin high", 0, 0, 0, 1, 8'h04, 0, 0, 1, '0);
        nop("R10 pin drops", 0);
        nop("R10 pin low", 0);
        step("R10 commit", 0, 0, 0, 0, 8'h00, 1, 0, 0, '0);
        peek("R10 commit ignores later pin", 8'h04);

        step("R5 set latch", 0, 1, 0, 0, 8'h00, 0, 0, 1, '0);
        step("R3 below quarter", 0, 0, 0, 0, 8'h00, 0, 0, 1, 14'h2FFF);
        step("R3 quarter start", 0, 0, 0, 0, 8'h00, 0, 0, 1, 14'h3000);

        step("R5 set and clear together", 0, 1, 1, 0, 8'h00, 0, 0, 1, '0);
        peek("R5 clear wins", 8'h04);

        step("R5 set latch", 0, 1, 0, 0, 8'h00, 0, 0, 1, '0);
        step("R9 accept 08", 0, 0, 0, 1, 8'h08, 0, 0, 1, '0);
        step("R9 brownout with done", 1, 0, 0, 0, 8'h00, 1, 0, 1, '0);
        peek("R9 pending dropped", 8'h04);

        step("R8 set while busy", 0, 1, 0, 0, 8'h00, 0, 1, 1, '0);
        peek("R8 set ignored while busy", 8'h05);
        nop("R8", 1);
        peek("R8 latch still clear", 8'h04);

        for (int i = 0; i < 4000; i++) begin
            step("R3 R5 R6 R8 random",
                 ($urandom % 40) == 0, ($urandom % 4) == 0, ($urandom % 12) == 0,
                 ($urandom % 5) == 0, 8'($urandom), ($urandom % 10) == 0,
                 ($urandom % 6) == 0, 1'($urandom), AW'($urandom));
        end

        summary();
        $finish;
    end
endmodule